// File: doc/BRIEF.md
# Single-Clock FIFO with Occupancy Thresholds

This block is a first-in first-out buffer on one clock. A producer pushes a word with `push_en` and a consumer pops one with `pop_en`. Both requests are gated inside the block, so a push into a full buffer and a pop from an empty one are simply dropped. The storage is an inferred array whose word width and power-of-two depth are parameters. The read and write pointers are one bit wider than the address, so wrap-around is tracked without any extra state.

The block keeps a registered occupancy count, `fill_level`. All four status outputs follow that count and are registered. `is_full` and `is_empty` mark the two ends of the range. `near_full` turns on once the count reaches `NEAR_FULL_AT` or more. `near_empty` stays on while the count is below `NEAR_EMPTY_BELOW`. Note that the two threshold comparisons are asymmetric.

A build-time switch, `OUT_STAGE`, adds a second register on the pop data path. This costs one cycle of read latency and gains timing margin. A synchronous clear, `flush`, empties the buffer without needing a reset.

Top module: `sync_fifo_thresh`

## Requirements
- R1: After `rst` is released, `fill_level` is 0, `is_empty` is 1, `is_full` is 0, `near_full` equals (0 >= NEAR_FULL_AT), `near_empty` equals (0 < NEAR_EMPTY_BELOW), and `pop_data` is 0.
- R2: Each rising edge updates `fill_level`. An accepted push alone adds one, an accepted pop alone subtracts one, and an accepted push and pop on the same edge leave it unchanged.
- R3: A push while `is_full` is 1 is dropped. `fill_level` does not change and the stored words stay as they were.
- R4: A pop while `is_empty` is 1 is dropped. `fill_level` stays 0 and `pop_data` does not change.
- R5: Words leave in the order they were accepted, including across pointer wrap-around.
- R6: `is_full` is 1 exactly when `fill_level` equals DEPTH, and `is_empty` is 1 exactly when `fill_level` is 0.
- R7: `near_full` is 1 exactly when `fill_level` is greater than or equal to NEAR_FULL_AT.
- R8: `near_empty` is 1 exactly when `fill_level` is strictly less than NEAR_EMPTY_BELOW.
- R9: Take a pop that is accepted on edge k. With OUT_STAGE=0 the popped word is on `pop_data` after edge k. With OUT_STAGE=1 it appears after edge k+1. Otherwise `pop_data` holds its value.
- R10: `flush` high on an edge overrides any push or pop on that same edge. After that edge `fill_level` is 0 and all flags are at their empty values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of the buffer contents |
| push_en | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop_en | input | 1 | Pop request |
| pop_data | output | DATA_W | Popped word |
| is_full | output | 1 | Occupancy equals DEPTH |
| is_empty | output | 1 | Occupancy is zero |
| near_full | output | 1 | Occupancy at or above NEAR_FULL_AT |
| near_empty | output | 1 | Occupancy below NEAR_EMPTY_BELOW |
| fill_level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The bench builds two copies of the block side by side with DEPTH=8, DATA_W=8, NEAR_FULL_AT=6 and NEAR_EMPTY_BELOW=3. The only difference between them is OUT_STAGE, which is 0 in one copy and 1 in the other. Both copies get the same stimulus, so every pop compares the one-cycle and two-cycle data latency directly. The small depth means a few pushes reach the full boundary and the overflow case. It also means an interleaved stream wraps the pointers several times. The two thresholds sit well inside the range, so both flags toggle on their own edges, away from the full and empty transitions.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } flag_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } op_t;

    function automatic flag_t level_flags(int unsigned cnt, int unsigned depth,
                                          int unsigned af_at, int unsigned ae_below);
        flag_t f;
        f.full   = (cnt == depth);
        f.empty  = (cnt == 0);
        f.afull  = (cnt >= af_at);
        f.aempty = (cnt < ae_below);
        return f;
    endfunction

    function automatic op_t accept(logic wr_req, logic rd_req, logic full, logic empty);
        op_t o;
        o.wr = wr_req & ~full;
        o.rd = rd_req & ~empty;
        return o;
    endfunction

endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AF_AT = 6,
    parameter int AE_BELOW = 3,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_req,
    input  logic              rd_req,
    output op_t               op,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  count,
    output flag_t             flags
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam flag_t IDLE_FLAGS = level_flags(0, DEPTH, AF_AT, AE_BELOW);

    logic [ADDR_W:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_nx;

    always_comb begin
        op = flush ? op_t'('0) : accept(wr_req, rd_req, flags.full, flags.empty);
        unique case ({op.wr, op.rd})
            2'b10:   count_nx = count + ONE;
            2'b01:   count_nx = count - ONE;
            default: count_nx = count;
        endcase
        if (flush) count_nx = '0;
    end

    assign wr_addr = wr_ptr[ADDR_W-1:0];
    assign rd_addr = rd_ptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            flags  <= IDLE_FLAGS;
        end else begin
            if (op.wr) wr_ptr <= wr_ptr + 1'b1;
            if (op.rd) rd_ptr <= rd_ptr + 1'b1;
            count <= count_nx;
            flags <= level_flags(32'(count_nx), DEPTH, AF_AT, AE_BELOW);
        end
    end

endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/sync_fifo_thresh.sv
module sync_fifo_thresh
    import fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH = 8,
    parameter int NEAR_FULL_AT = 6,
    parameter int NEAR_EMPTY_BELOW = 3,
    parameter bit OUT_STAGE = 1'b0,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic [DATA_W-1:0] pop_data,
    output logic              is_full,
    output logic              is_empty,
    output logic              near_full,
    output logic              near_empty,
    output logic [CNT_W-1:0]  fill_level
);
    op_t               op;
    flag_t             flg;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] mem_q;

    fifo_ctrl #(.DEPTH(DEPTH), .AF_AT(NEAR_FULL_AT), .AE_BELOW(NEAR_EMPTY_BELOW)) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_req(push_en), .rd_req(pop_en),
        .op(op), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .count(fill_level), .flags(flg)
    );

    fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .we(op.wr), .waddr(wr_addr), .wdata(push_data),
        .re(op.rd), .raddr(rd_addr), .rdata(mem_q)
    );

    generate
        if (OUT_STAGE) begin : g_out_reg
            logic              q_vld;
            logic [DATA_W-1:0] q_hold;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_vld  <= 1'b0;
                    q_hold <= '0;
                end else begin
                    q_vld <= op.rd;
                    if (q_vld) q_hold <= mem_q;
                end
            end
            assign pop_data = q_hold;
        end else begin : g_out_direct
            assign pop_data = mem_q;
        end
    endgenerate

    assign is_full    = flg.full;
    assign is_empty   = flg.empty;
    assign near_full  = flg.afull;
    assign near_empty = flg.aempty;

endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
    parameter int DEPTH = 8,
    parameter int NEAR_FULL_AT = 6,
    parameter int NEAR_EMPTY_BELOW = 3,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             push_en,
    input logic             pop_en,
    input logic             is_full,
    input logic             is_empty,
    input logic             near_full,
    input logic             near_empty,
    input logic [CNT_W-1:0] fill_level
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] AF_C    = CNT_W'(NEAR_FULL_AT);
    localparam logic [CNT_W-1:0] AE_C    = CNT_W'(NEAR_EMPTY_BELOW);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        is_full == (fill_level == DEPTH_C)); // R6
    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        is_empty == (fill_level == '0)); // R6
    AST_NEAR_FULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        near_full == (fill_level >= AF_C)); // R7
    AST_NEAR_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        near_empty == (fill_level < AE_C)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_en && !pop_en && !flush) |=> (is_full && fill_level == $past(fill_level))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop_en && !push_en && !flush) |=> (is_empty && fill_level == '0)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (fill_level == $past(fill_level) || fill_level == $past(fill_level) + ONE
                    || fill_level == $past(fill_level) - ONE)); // R2
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_level == '0 && is_empty && !is_full)); // R10

endmodule

bind sync_fifo_thresh fifo_chk #(
    .DEPTH(DEPTH), .NEAR_FULL_AT(NEAR_FULL_AT), .NEAR_EMPTY_BELOW(NEAR_EMPTY_BELOW)
) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .push_en(push_en), .pop_en(pop_en),
    .is_full(is_full), .is_empty(is_empty), .near_full(near_full),
    .near_empty(near_empty), .fill_level(fill_level)
);

// File: tb/tb_sync_fifo_thresh.sv
module tb_sync_fifo_thresh;
    localparam int PERIOD = 10;
    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int AF = 6;
    localparam int AE = 3;
    localparam int CW = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic push_en = 1'b0;
    logic pop_en = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] q_a, q_b;
    logic full_a, empty_a, af_a, ae_a, full_b, empty_b, af_b, ae_b;
    logic [CW-1:0] lvl_a, lvl_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int model[$];
    int m_cnt = 0;
    int m_q0 = 0;
    int m_q1 = 0;
    bit m_pend = 0;

    always #(PERIOD/2) clk = ~clk;

    sync_fifo_thresh #(.DATA_W(DW), .DEPTH(DEPTH), .NEAR_FULL_AT(AF),
                       .NEAR_EMPTY_BELOW(AE), .OUT_STAGE(1'b0)) dut (
        .clk(clk), .rst(rst), .flush(flush), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(q_a), .is_full(full_a), .is_empty(empty_a),
        .near_full(af_a), .near_empty(ae_a), .fill_level(lvl_a));

    sync_fifo_thresh #(.DATA_W(DW), .DEPTH(DEPTH), .NEAR_FULL_AT(AF),
                       .NEAR_EMPTY_BELOW(AE), .OUT_STAGE(1'b1)) dut_reg (
        .clk(clk), .rst(rst), .flush(flush), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(q_b), .is_full(full_b), .is_empty(empty_b),
        .near_full(af_b), .near_empty(ae_b), .fill_level(lvl_b));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_state();
        chk("R2 fill_level", int'(lvl_a), m_cnt);
        chk("R2 fill_level reg", int'(lvl_b), m_cnt);
        chk("R6 full", int'(full_a), int'(m_cnt == DEPTH));
        chk("R6 empty", int'(empty_a), int'(m_cnt == 0));
        chk("R6 full reg", int'(full_b), int'(m_cnt == DEPTH));
        chk("R7 near_full", int'(af_a), int'(m_cnt >= AF));
        chk("R7 near_full reg", int'(af_b), int'(m_cnt >= AF));
        chk("R8 near_empty", int'(ae_a), int'(m_cnt < AE));
        chk("R8 near_empty reg", int'(ae_b), int'(m_cnt < AE));
        chk("R5 R9 pop_data", int'(q_a), m_q0);
        chk("R5 R9 pop_data reg", int'(q_b), m_q1);
    endtask

    task automatic step(bit wr, int d, bit rd, bit clr);
        bit wa, ra;
        @(negedge clk);
        push_en = wr; push_data = DW'(d); pop_en = rd; flush = clr;
        @(posedge clk);
        #1;
        wa = !clr && wr && (m_cnt < DEPTH);
        ra = !clr && rd && (m_cnt > 0);
        if (m_pend) m_q1 = m_q0;
        if (ra) begin m_q0 = model.pop_front(); m_cnt--; end
        m_pend = ra;
        if (wa) begin model.push_back(d); m_cnt++; end
        if (clr) begin model.delete(); m_cnt = 0; end
        check_state();
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 fill_level", int'(lvl_a), 0);
        chk("R1 empty", int'(empty_a), 1);
        chk("R1 full", int'(full_a), 0);
        chk("R1 near_full", int'(af_a), 0);
        chk("R1 near_empty", int'(ae_a), 1);
        chk("R1 pop_data", int'(q_a), 0);
        chk("R1 pop_data reg", int'(q_b), 0);
    endtask

    task automatic t_underflow();
        step(0, 0, 1, 0);
        chk("R4 level after empty pop", int'(lvl_a), 0);
        chk("R4 pop_data held", int'(q_a), 0);
        chk("R4 pop_data reg held", int'(q_b), 0);
    endtask

    task automatic t_latency();
        step(1, 8'hA5, 0, 0);
        step(0, 0, 1, 0);
        chk("R9 direct data after accept edge", int'(q_a), 8'hA5);
        chk("R9 staged data not yet", int'(q_b), 0);
        step(0, 0, 0, 0);
        chk("R9 staged data one edge later", int'(q_b), 8'hA5);
        step(0, 0, 1, 0);
        chk("R4 pop_data held after empty pop", int'(q_a), 8'hA5);
        step(0, 0, 0, 0);
        chk("R4 staged pop_data held", int'(q_b), 8'hA5);
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) step(1, 16 + i, 0, 0);
        chk("R6 full at depth", int'(full_a), 1);
        step(1, 8'hEE, 0, 0);
        step(1, 8'hEF, 0, 0);
        chk("R3 level unchanged while full", int'(lvl_a), DEPTH);
        step(1, 8'hEE, 1, 0);
        chk("R3 full pop with push", int'(lvl_a), DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 1, 0);
            chk("R3 no dropped word stored", int'(q_a != 8'hEE && q_a != 8'hEF), 1);
        end
        step(0, 0, 0, 0);
    endtask

    task automatic t_simul();
        for (int i = 0; i < 4; i++) step(1, 40 + i, 0, 0);
        step(1, 50, 1, 0);
        chk("R2 simultaneous keeps level", int'(lvl_a), 4);
        for (int i = 0; i < 6; i++) step(1, 60 + i, 1, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 30; i++) step(1, 100 + i, (i % 3) != 0, 0);
        while (m_cnt > 0) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 7; i++) step(1, 200 + i, 0, 0);
        step(1, 250, 1, 1);
        chk("R10 flush level", int'(lvl_a), 0);
        chk("R10 flush empty", int'(empty_a), 1);
        chk("R10 flush near_full off", int'(af_a), 0);
        chk("R10 flush near_empty on", int'(ae_a), 1);
        step(1, 77, 0, 0);
        step(0, 0, 1, 0);
        chk("R10 first word after flush", int'(q_a), 77);
        step(0, 0, 0, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_underflow();
        t_latency();
        t_fill_overflow();
        t_simul();
        t_wrap();
        t_flush();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule